// File: doc/BRIEF.md
# I2C Interrupt Status Flags

This block holds three sticky raw interrupt flags for an I2C controller: transfer done, not-acknowledge and arbitration lost. The bus engine feeds it one-cycle event pulses (byte count reached zero, byte count passed zero, stop or repeated start seen on the bus, NACK seen, arbitration lost, start requested), the receive-FIFO-empty level and the current mode: master or slave, transmit or receive, and whether an automatic stop is armed.

Software reads the flags through a simple port. It clears a flag by writing 1 to that flag's bit. The block merges the flags with an enable mask into one interrupt line.

A NACK or a lost arbitration ends the transfer. On either event the block sends single-cycle requests that clear the master-mode and auto-stop control bits held elsewhere. A lost arbitration also sends a request that puts the controller into receive mode.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, `reg_rdata_o` is 0 and `irq_o`, `clr_master_o`, `clr_stop_o` and `force_rx_o` are all low. The flag layout is: bit 2 is done, bit 1 is NACK, bit 0 is arbitration lost.
- R2: A write with bit i of `reg_wdata_i` at 1 clears flag i. A write with bit i at 0 leaves flag i unchanged.
- R3: If a flag's set event and a write-1 clear of that flag land in the same cycle, the flag is 1 after that edge.
- R4: In master transmit with auto-stop on, a count-zero pulse sets the done flag after that edge. A count-passed pulse has no effect in this mode.
- R5: In master mode with auto-stop off, a count-passed pulse sets the done flag. In transmit this happens at once. In receive it happens only once the receive FIFO is empty.
- R6: In master receive with auto-stop on, a count-zero pulse sets the done flag only when the receive FIFO is empty.
- R7: In slave mode, a stop or repeated-start pulse sets the done flag. In transmit this happens at once. In receive it happens only once the receive FIFO is empty.
- R8: A receive-mode done condition that arrives while the FIFO holds data stays pending. The done flag sets at the edge of the first cycle in which `rx_empty_i` is 1.
- R9: A NACK pulse sets bit 1. After the same edge it raises `clr_master_o` and `clr_stop_o`, with `force_rx_o` low.
- R10: Bit 0 sets, and `clr_master_o`, `clr_stop_o` and `force_rx_o` pulse, in two cases: arbitration is lost while in master mode, or a start is requested while the bus is busy. An arbitration-lost pulse in slave mode has no effect.
- R11: `irq_o` is 1 exactly when some flag i is set and bit i of `irq_en_i` is 1.
- R12: The clear and receive-mode requests last one cycle, even when the fault input stays high for several cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| transmit_i | input | 1 | 1 = transmit, 0 = receive |
| stop_en_i | input | 1 | Auto-stop armed |
| rx_empty_i | input | 1 | Receive FIFO empty level |
| cnt_zero_i | input | 1 | Byte count reached zero pulse |
| cnt_passed_i | input | 1 | Byte count passed zero pulse |
| stop_rx_i | input | 1 | Stop or repeated start received pulse |
| nack_i | input | 1 | NACK received pulse |
| arb_lost_i | input | 1 | Arbitration lost in address phase pulse |
| start_req_i | input | 1 | Start requested pulse |
| bus_busy_i | input | 1 | Bus busy level |
| reg_we_i | input | 1 | Flag register write strobe |
| reg_wdata_i | input | 3 | Write-1-to-clear data |
| irq_en_i | input | 3 | Interrupt enable mask, one bit per flag |
| reg_rdata_o | output | 3 | Flag read value |
| irq_o | output | 1 | Combined masked interrupt |
| clr_master_o | output | 1 | Clear request for the master-mode bit |
| clr_stop_o | output | 1 | Clear request for the auto-stop bit |
| force_rx_o | output | 1 | Request to enter receive mode |

## Verification
The assertions expect every event input to be a one-cycle pulse. They also expect the mode inputs to stay stable while a done condition is pending. Under those inputs, a flag that is set stays set until a write-1 clears it, a pending receive condition clears once the FIFO reports empty, and each clear request lasts exactly one cycle. The stimulus changes inputs only on the falling edge. It holds the mode steady across each event, and every event is a single pulse except in the one case that holds a fault input high to test the one-cycle request width.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned FLAG_DONE = 2;
  localparam int unsigned FLAG_NACK = 1;
  localparam int unsigned FLAG_ARB  = 0;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_irq_done_det.sv
module i2c_irq_done_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic transmit_i,
  input  logic stop_en_i,
  input  logic rx_empty_i,
  input  logic cnt_zero_i,
  input  logic cnt_passed_i,
  input  logic stop_rx_i,
  output logic set_o
);
  logic evt, pend_q, pend_d;

  // select the completion event for the current mode
  always_comb begin
    if (master_i) evt = stop_en_i ? cnt_zero_i : cnt_passed_i;
    else          evt = stop_rx_i;
  end

  always_comb begin
    set_o  = (evt && (transmit_i || rx_empty_i)) || (pend_q && rx_empty_i);
    pend_d = pend_q;
    if (rx_empty_i)                    pend_d = 1'b0;
    else if (evt && !transmit_i)       pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // R8
  pend_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && rx_empty_i |=> !pend_q);
  // R8
  pend_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && !transmit_i && !rx_empty_i |=> pend_q);
endmodule

// File: rtl/i2c_irq_fault_det.sv
module i2c_irq_fault_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic nack_i,
  input  logic arb_lost_i,
  input  logic start_req_i,
  input  logic bus_busy_i,
  output logic nack_set_o,
  output logic arb_set_o,
  output logic clr_master_o,
  output logic clr_stop_o,
  output logic force_rx_o
);
  logic fault, nack_q, arb_q, clr_q, rx_q;

  assign nack_set_o = nack_i;
  assign arb_set_o  = (master_i && arb_lost_i) || (start_req_i && bus_busy_i);
  assign fault      = nack_set_o || arb_set_o;

  // requests fire only on the first cycle of a fault
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_q <= 1'b0;
      arb_q  <= 1'b0;
      clr_q  <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      nack_q <= nack_set_o;
      arb_q  <= arb_set_o;
      clr_q  <= fault && !(nack_q || arb_q);
      rx_q   <= arb_set_o && !arb_q;
    end
  end

  assign clr_master_o = clr_q;
  assign clr_stop_o   = clr_q;
  assign force_rx_o   = rx_q;

  // R12
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_master_o |=> !clr_master_o);
  // R12
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_rx_o |=> !force_rx_o);
  // R9
  nack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i && !nack_q && !arb_q |=> clr_master_o && clr_stop_o);
  // R10
  arb_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_rx_o |-> clr_stop_o);
endmodule

// File: rtl/i2c_irq_flag_reg.sv
module i2c_irq_flag_reg #(
  parameter int unsigned W = i2c_irq_pkg::FLAG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q <= 1'b0;
      else if (set_i[i])              q <= 1'b1;
      else if (we_i && wdata_i[i])    q <= 1'b0;
    end
    assign flag_o[i] = q;

    // R2
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && wdata_i[i] && !set_i[i] |=> !flag_o[i]);
    // R2
    w0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[i] && !(we_i && wdata_i[i]) |=> flag_o[i]);
    // R3
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int unsigned NFLAG = FLAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             transmit_i,
  input  logic             stop_en_i,
  input  logic             rx_empty_i,
  input  logic             cnt_zero_i,
  input  logic             cnt_passed_i,
  input  logic             stop_rx_i,
  input  logic             nack_i,
  input  logic             arb_lost_i,
  input  logic             start_req_i,
  input  logic             bus_busy_i,
  input  logic             reg_we_i,
  input  logic [NFLAG-1:0] reg_wdata_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic [NFLAG-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             clr_master_o,
  output logic             clr_stop_o,
  output logic             force_rx_o
);
  logic done_set, nack_set, arb_set;
  logic [NFLAG-1:0] set_vec, flags;

  i2c_irq_done_det u_done (
    .clk_i, .rst_ni, .master_i, .transmit_i, .stop_en_i, .rx_empty_i,
    .cnt_zero_i, .cnt_passed_i, .stop_rx_i, .set_o(done_set)
  );

  i2c_irq_fault_det u_fault (
    .clk_i, .rst_ni, .master_i, .nack_i, .arb_lost_i, .start_req_i,
    .bus_busy_i, .nack_set_o(nack_set), .arb_set_o(arb_set),
    .clr_master_o, .clr_stop_o, .force_rx_o
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_DONE] = done_set;
    set_vec[FLAG_NACK] = nack_set;
    set_vec[FLAG_ARB]  = arb_set;
  end

  i2c_irq_flag_reg #(.W(NFLAG)) u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .flag_o(flags)
  );

  assign reg_rdata_o = flags;
  assign irq_o       = |(flags & irq_en_i);

  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i == '0 |-> !irq_o);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> reg_rdata_o == '0 && !clr_master_o && !force_rx_o);
endmodule

// File: tb/sim_i2c_irq_status.sv
`timescale 1ns/1ps
module sim_i2c_irq_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 0, transmit = 0, stop_en = 0, rx_empty = 1;
  logic cnt_zero = 0, cnt_passed = 0, stop_rx = 0, nack = 0, arb_lost = 0;
  logic start_req = 0, bus_busy = 0, we = 0;
  logic [2:0] wdata = 0, irq_en = 0, rdata;
  logic irq, clr_m, clr_s, frx;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_irq_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .transmit_i(transmit),
    .stop_en_i(stop_en), .rx_empty_i(rx_empty), .cnt_zero_i(cnt_zero),
    .cnt_passed_i(cnt_passed), .stop_rx_i(stop_rx), .nack_i(nack),
    .arb_lost_i(arb_lost), .start_req_i(start_req), .bus_busy_i(bus_busy),
    .reg_we_i(we), .reg_wdata_i(wdata), .irq_en_i(irq_en),
    .reg_rdata_o(rdata), .irq_o(irq), .clr_master_o(clr_m),
    .clr_stop_o(clr_s), .force_rx_o(frx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk); we = 1; wdata = m;
    tick();
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic set_mode(logic m, logic t, logic s);
    @(negedge clk); master = m; transmit = t; stop_en = s;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 clr", {clr_m, clr_s, frx}, 0);
  endtask

  task automatic t_mtx_stop();
    set_mode(1, 1, 1);
    @(negedge clk); cnt_passed = 1; tick(); @(negedge clk); cnt_passed = 0;
    chk("R4 passed ignored", rdata, 3'b000);
    @(negedge clk); cnt_zero = 1; tick();
    chk("R4 zero sets done", rdata, 3'b100);
    @(negedge clk); cnt_zero = 0;
    clear(3'b011); tick();
    chk("R2 write0 keeps", rdata, 3'b100);
    clear(3'b100);
    chk("R2 write1 clears", rdata, 3'b000);
  endtask

  task automatic t_mrx_stop();
    set_mode(1, 0, 1);
    @(negedge clk); rx_empty = 1; cnt_zero = 1; tick();
    chk("R6 empty sets done", rdata, 3'b100);
    @(negedge clk); cnt_zero = 0;
    clear(3'b100);
  endtask

  task automatic t_pending();
    set_mode(1, 0, 0);
    @(negedge clk); rx_empty = 0; cnt_passed = 1; tick();
    chk("R5 rx not empty waits", rdata, 3'b000);
    @(negedge clk); cnt_passed = 0; tick(); tick();
    chk("R8 still pending", rdata, 3'b000);
    @(negedge clk); rx_empty = 1; tick();
    chk("R8 sets on empty", rdata, 3'b100);
    clear(3'b100); tick();
    chk("R8 no repeat", rdata, 3'b000);
  endtask

  task automatic t_mtx_nostop();
    set_mode(1, 1, 0);
    @(negedge clk); rx_empty = 0; cnt_passed = 1; tick();
    chk("R5 tx passed sets", rdata, 3'b100);
    @(negedge clk); cnt_passed = 0; rx_empty = 1;
    clear(3'b100);
  endtask

  task automatic t_slave();
    set_mode(0, 1, 0);
    @(negedge clk); rx_empty = 0; stop_rx = 1; tick();
    chk("R7 slave tx stop sets", rdata, 3'b100);
    @(negedge clk); stop_rx = 0;
    clear(3'b100);
    set_mode(0, 0, 0);
    @(negedge clk); stop_rx = 1; tick();
    chk("R7 slave rx waits", rdata, 3'b000);
    @(negedge clk); stop_rx = 0; rx_empty = 1; tick();
    chk("R7 slave rx sets on empty", rdata, 3'b100);
    clear(3'b100);
  endtask

  task automatic t_nack();
    set_mode(1, 1, 1);
    @(negedge clk); nack = 1; tick();
    chk("R9 nack flag", rdata, 3'b010);
    chk("R9 clr pulses", {clr_m, clr_s, frx}, 3'b110);
    tick();
    chk("R12 clr one cycle", {clr_m, clr_s}, 2'b00);
    tick();
    @(negedge clk); nack = 0;
    clear(3'b010);
    chk("R2 nack cleared", rdata, 0);
  endtask

  task automatic t_arb();
    set_mode(0, 1, 0);
    @(negedge clk); arb_lost = 1; tick();
    chk("R10 slave arb ignored", {rdata, clr_m}, 0);
    @(negedge clk); arb_lost = 0;
    set_mode(1, 1, 0);
    @(negedge clk); arb_lost = 1; tick();
    chk("R10 arb flag", rdata, 3'b001);
    chk("R10 requests", {clr_m, clr_s, frx}, 3'b111);
    @(negedge clk); arb_lost = 0; tick();
    chk("R12 force_rx one cycle", frx, 0);
    clear(3'b001);
    @(negedge clk); bus_busy = 1; start_req = 1; tick();
    chk("R10 start while busy", rdata, 3'b001);
    @(negedge clk); start_req = 0; bus_busy = 0;
    clear(3'b001);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); nack = 1; we = 1; wdata = 3'b010; tick();
    chk("R3 set wins", rdata, 3'b010);
    @(negedge clk); nack = 0; we = 0; wdata = 0;
  endtask

  task automatic t_irq();
    set_mode(1, 1, 1);
    @(negedge clk); cnt_zero = 1; tick();
    @(negedge clk); cnt_zero = 0; irq_en = 3'b001; #1;
    chk("R11 masked", irq, 0);
    irq_en = 3'b010; #1;
    chk("R11 nack enabled", irq, 1);
    irq_en = 3'b100; #1;
    chk("R11 done enabled", irq, 1);
    clear(3'b110); #1;
    chk("R11 cleared", irq, 0);
    irq_en = 0;
  endtask

  initial begin
    #20000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1; t_reset();
    #9; @(negedge clk); rst_n = 1;
    tick();
    t_reset();
    t_mtx_stop();
    t_mrx_stop();
    t_pending();
    t_mtx_nostop();
    t_slave();
    t_nack();
    t_arb();
    t_same_cycle();
    t_irq();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule